// File: doc/BRIEF.md
# Leading/Trailing Zero Counter

This unit counts the run of zero bits at one end of a 64-bit operand. A direction select picks which end the count starts from: the most significant end (leading zeros) or the least significant end (trailing zeros). A size select picks between a full 64-bit doubleword count and a 32-bit word count. In word mode only the low 32 bits are examined.

The count comes back zero-extended to 64 bits, so it can drop straight onto a result bus. When no bit in the examined field is set, the count equals the field width: 64 for a doubleword and 32 for a word.

The block is purely combinational and holds no state. One priority encoder serves all four combinations of direction and size. For a trailing count, the selected field is bit-reversed so that the encoder only ever looks for the highest set bit. For a word count, the 32-bit field is moved to the top of the encoder input, with a guard bit below it that caps the count at 32.

Top module: `zcnt_top`

## Requirements
- R1: In doubleword mode (`word_mode_i`=0), an all-zero 64-bit operand gives `count_o` = 64 for both directions.
- R2: In word mode (`word_mode_i`=1), an operand whose bits 31..0 are all zero gives `count_o` = 32 for both directions, whatever bits 63..32 hold.
- R3: A leading count in doubleword mode gives 63 minus the index of the highest set bit of the operand, a value from 0 to 63.
- R4: A leading count in word mode gives 31 minus the index of the highest set bit among bits 31..0, a value from 0 to 31.
- R5: A trailing count in doubleword mode gives the index of the lowest set bit of the operand, a value from 0 to 63.
- R6: A trailing count in word mode gives the index of the lowest set bit among bits 31..0. If none of those bits is set, the result is 32.
- R7: In word mode, bits 63..32 of the operand have no effect on `count_o`.
- R8: `count_o` is zero-extended. Bits 63..7 are always 0, the value never exceeds 64, and in word mode it never exceeds 32.
- R9: `trailing_i`=0 selects a leading-zero count and `trailing_i`=1 selects a trailing-zero count. The output follows any input change combinationally, with no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_i | input | 64 | Value whose zero run is counted |
| word_mode_i | input | 1 | 1 = examine bits 31..0 only; 0 = examine all 64 bits |
| trailing_i | input | 1 | 0 = count from the top end; 1 = count from the bottom end |
| count_o | output | 64 | Zero-extended zero count |

## Verification
The embedded checks are immediate assertions evaluated inside combinational blocks. They assume that all three inputs are two-state and that they change together, so that no check sees a half-updated mix of operand and mode. The bench keeps to this rule in two ways: it drives the operand and both selects in one step on a rising edge, and it reads the count half a period later, after the logic has settled. Patterns with a single marker bit at every position in all four modes are mixed with pseudo-random filler bits on the side that must not matter, including junk in the upper word during word-mode runs.

// File: rtl/zcnt_pkg.sv
package zcnt_pkg;

    // operating mode decoded from the two select inputs
    typedef struct packed {
        logic word;   // 1: low-word field only
        logic trail;  // 1: count from the bottom end
    } zc_mode_t;

endpackage

// File: rtl/zcnt_bitrev.sv
module zcnt_bitrev #(
    parameter int W = 32
) (
    input  logic [W-1:0] in_i,
    output logic [W-1:0] out_o
);

    for (genvar gi = 0; gi < W; gi++) begin : g_rev
        assign out_o[gi] = in_i[W-1-gi];
    end

endmodule

// File: rtl/zcnt_prep.sv
// Arranges the operand so that the count is always "zeros above the
// highest set bit" of a DATA_W-wide vector.
module zcnt_prep
    import zcnt_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int WORD_W = 32
) (
    input  logic [DATA_W-1:0] operand_i,
    input  zc_mode_t          mode_i,
    output logic [DATA_W-1:0] vec_o
);

    localparam int GUARD_POS = DATA_W - WORD_W - 1;

    logic [DATA_W-1:0] rev_full;
    logic [WORD_W-1:0] rev_word;

    zcnt_bitrev #(.W(DATA_W)) u_rev_full (
        .in_i  (operand_i),
        .out_o (rev_full)
    );

    zcnt_bitrev #(.W(WORD_W)) u_rev_word (
        .in_i  (operand_i[WORD_W-1:0]),
        .out_o (rev_word)
    );

    logic [DATA_W-1:0] vec_d;
    logic [WORD_W-1:0] wsrc_d;

    always_comb begin
        wsrc_d = mode_i.trail ? rev_word : operand_i[WORD_W-1:0];
        if (mode_i.word) begin
            vec_d                        = '0;
            vec_d[DATA_W-1 -: WORD_W]    = wsrc_d;
            vec_d[GUARD_POS]             = 1'b1;  // caps the count at WORD_W
        end else begin
            vec_d = mode_i.trail ? rev_full : operand_i;
        end
    end

    assign vec_o = vec_d;

endmodule

// File: rtl/zcnt_lead_enc.sv
// Priority encoder: number of zero bits above the highest set bit.
module zcnt_lead_enc #(
    parameter int W     = 64,
    parameter int CNT_W = $clog2(W + 1)
) (
    input  logic [W-1:0]     vec_i,
    output logic [CNT_W-1:0] cnt_o
);

    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        cnt_d = CNT_W'(W);
        for (int i = 0; i < W; i++) begin
            if (vec_i[i]) cnt_d = CNT_W'(W - 1 - i);
        end

        // R8: the count stays inside 0..W
        a_r8_enc_range: assert (int'(cnt_d) <= W)
            else $error("encoder count %0d above %0d", cnt_d, W);
        // R1: full-width count exactly when nothing is set
        a_r1_enc_empty: assert ((int'(cnt_d) == W) == (vec_i == '0))
            else $error("encoder empty mismatch cnt=%0d", cnt_d);
        // R3: the bit just below the zero run is set, all above it clear
        if (int'(cnt_d) < W) begin
            a_r3_enc_marker: assert (vec_i[W - 1 - int'(cnt_d)] &&
                                     ((vec_i >> (W - int'(cnt_d))) == '0))
                else $error("encoder marker wrong cnt=%0d", cnt_d);
        end
    end

    assign cnt_o = cnt_d;

endmodule

// File: rtl/zcnt_top.sv
module zcnt_top
    import zcnt_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int WORD_W = 32
) (
    input  logic [DATA_W-1:0] operand_i,
    input  logic              word_mode_i,
    input  logic              trailing_i,
    output logic [DATA_W-1:0] count_o
);

    localparam int CNT_W = $clog2(DATA_W + 1);

    zc_mode_t          mode_d;
    logic [DATA_W-1:0] vec;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] count_d;

    assign mode_d.word  = word_mode_i;
    assign mode_d.trail = trailing_i;

    zcnt_prep #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_prep (
        .operand_i (operand_i),
        .mode_i    (mode_d),
        .vec_o     (vec)
    );

    zcnt_lead_enc #(.W(DATA_W), .CNT_W(CNT_W)) u_enc (
        .vec_i (vec),
        .cnt_o (cnt)
    );

    always_comb begin
        count_d = {{(DATA_W - CNT_W){1'b0}}, cnt};

        // R2: word-mode results never pass the word width
        if (word_mode_i) begin
            a_r2_word_cap: assert (count_d <= DATA_W'(WORD_W))
                else $error("word count %0d above %0d", count_d, WORD_W);
        end
        // R1: doubleword result never passes the full width
        a_r1_dword_cap: assert (count_d <= DATA_W'(DATA_W))
            else $error("count %0d above %0d", count_d, DATA_W);
        // R6: low word empty in word mode means a count of exactly WORD_W
        if (word_mode_i && operand_i[WORD_W-1:0] == '0) begin
            a_r6_word_empty: assert (count_d == DATA_W'(WORD_W))
                else $error("empty word gave %0d", count_d);
        end
    end

    assign count_o = count_d;

endmodule

// File: tb/zcnt_top_tb.sv
module zcnt_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic [63:0] operand;
    logic        word_mode;
    logic        trailing;
    logic [63:0] count;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;

    zcnt_top dut_i (
        .operand_i   (operand),
        .word_mode_i (word_mode),
        .trailing_i  (trailing),
        .count_o     (count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            failures = failures + 1;
            $display("FAIL watchdog: run hung, cycles=%0d expected<=%0d", cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
            $finish;
        end
    end

    typedef struct packed {
        logic [63:0] op;
        logic        word;
        logic        trail;
        logic [63:0] exp;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{64'h0,                   1'b0, 1'b0, 64'd64},  // R1
        '{64'h0,                   1'b0, 1'b1, 64'd64},  // R1
        '{64'h0,                   1'b1, 1'b0, 64'd32},  // R2
        '{64'h0,                   1'b1, 1'b1, 64'd32},  // R2
        '{64'hFFFF_FFFF_0000_0000, 1'b1, 1'b0, 64'd32},  // R7
        '{64'hFFFF_FFFF_0000_0000, 1'b1, 1'b1, 64'd32},  // R7
        '{64'h8000_0000_0000_0000, 1'b0, 1'b0, 64'd0},   // R3
        '{64'h8000_0000_0000_0000, 1'b0, 1'b1, 64'd63},  // R5
        '{64'h0000_0000_0000_0001, 1'b0, 1'b0, 64'd63},  // R3
        '{64'h0000_0000_0000_0001, 1'b0, 1'b1, 64'd0},   // R5
        '{64'h0000_0000_8000_0000, 1'b1, 1'b0, 64'd0},   // R4
        '{64'h0000_0000_8000_0000, 1'b1, 1'b1, 64'd31},  // R6
        '{64'h0000_0000_8000_0000, 1'b0, 1'b0, 64'd32},  // R3
        '{64'h0000_0001_0000_0000, 1'b0, 1'b1, 64'd32},  // R5
        '{64'h0000_0001_0000_0000, 1'b1, 1'b1, 64'd32},  // R6
        '{64'hF0F0_0000_0001_0000, 1'b1, 1'b0, 64'd15},  // R4
        '{64'hF0F0_0000_0001_0000, 1'b1, 1'b1, 64'd16},  // R6
        '{64'hF0F0_0000_0001_0000, 1'b0, 1'b0, 64'd0},   // R9
        '{64'hF0F0_0000_0001_0000, 1'b0, 1'b1, 64'd16},  // R9
        '{64'h0000_0000_0000_0100, 1'b1, 1'b0, 64'd23}   // R4
    };

    logic [63:0] lfsr = 64'hACE1_2468_9BDF_1357;

    task automatic step_lfsr();
        lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
    endtask

    task automatic apply_check(input logic [63:0] op, input logic wm, input logic tr,
                               input logic [63:0] exp, input string tag);
        @(posedge clk);
        operand   = op;
        word_mode = wm;
        trailing  = tr;
        @(negedge clk);
        checks = checks + 1;
        if (count !== exp) begin
            failures = failures + 1;
            $display("FAIL %s: op=%h word=%0b trail=%0b actual=%0d expected=%0d",
                     tag, op, wm, tr, count, exp);
        end
        // R8: upper bits always clear
        checks = checks + 1;
        if (count[63:7] !== '0) begin
            failures = failures + 1;
            $display("FAIL R8: upper bits actual=%h expected=0", count[63:7]);
        end
    endtask

    initial begin
        operand   = '0;
        word_mode = 1'b0;
        trailing  = 1'b0;

        // initial state: all-zero inputs, doubleword leading count (R1)
        @(negedge clk);
        checks = checks + 1;
        if (count !== 64'd64) begin
            failures = failures + 1;
            $display("FAIL R1: initial actual=%0d expected=64", count);
        end

        for (int k = 0; k < NV; k++) begin
            apply_check(VECS[k].op, VECS[k].word, VECS[k].trail, VECS[k].exp, "table");
        end

        // R3 / R9: leading doubleword, marker at i, random bits below it
        for (int i = 0; i < 64; i++) begin
            logic [63:0] op;
            step_lfsr();
            op = (64'd1 << i) | (lfsr & ((64'd1 << i) - 64'd1));
            apply_check(op, 1'b0, 1'b0, 64'(63 - i), "R3");
        end

        // R5 / R9: trailing doubleword, marker at i, random bits above it
        for (int i = 0; i < 64; i++) begin
            logic [63:0] op;
            step_lfsr();
            op = (64'd1 << i) | (lfsr & ~((64'd1 << (i + 1)) - 64'd1));
            apply_check(op, 1'b0, 1'b1, 64'(i), "R5");
        end

        // R4 / R7: leading word, random junk in the upper word
        for (int i = 0; i < 32; i++) begin
            logic [63:0] op;
            step_lfsr();
            op = (64'd1 << i) | (lfsr & ((64'd1 << i) - 64'd1));
            op[63:32] = lfsr[63:32] ^ 32'h5A5A_A5A5;
            apply_check(op, 1'b1, 1'b0, 64'(31 - i), "R4");
        end

        // R6 / R7: trailing word, random junk above the marker
        for (int i = 0; i < 64; i++) begin
            logic [63:0] op;
            step_lfsr();
            op = (64'd1 << i) | (lfsr & ~((64'd1 << (i + 1)) - 64'd1));
            apply_check(op, 1'b1, 1'b1, (i < 32) ? 64'(i) : 64'd32, "R6");
        end

        // R7: only the upper word changes, word-mode count must not move
        for (int k = 0; k < 8; k++) begin
            step_lfsr();
            apply_check({lfsr[63:32], 32'h0004_0000}, 1'b1, 1'b0, 64'd13, "R7");
            apply_check({lfsr[31:0],  32'h0004_0000}, 1'b1, 1'b1, 64'd18, "R7");
        end

        // R2: empty low word with a full upper word
        apply_check(64'hFFFF_FFFF_0000_0000, 1'b1, 1'b0, 64'd32, "R2");
        apply_check(64'hFFFF_FFFF_0000_0000, 1'b1, 1'b1, 64'd32, "R2");
        // R1 again after other traffic
        apply_check(64'h0, 1'b0, 1'b1, 64'd64, "R1");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
        $finish;
    end

endmodule